// File: doc/BRIEF.md
# E1 Line Loopback and Alarm Insertion

This block steers single-bit binary data between the line decoder/encoder pair and the frame memory of a 2.048 Mb/s E1 framer. Three loopback points can be closed. The line loop turns outgoing data back into the receive side at the pins. The codec loop returns received data to the line. The frame loop feeds transmitter frames into frame memory. Independently of the loops, the transmit stream can be overridden by an all-ones or an alternating 0/1 alarm pattern, or by a test mode that puts isolated single pulses of alternating polarity on two line rails.

The control inputs are captured into a control word on each bit-clock enable. The datapath runs from that word, and every output is registered on the bit-clock enable. Data therefore appears one enable after it is presented. A control change takes effect on the second enable after it is applied. After reset the control word has only the line loop closed.

Top module: `e1_line_loop`

## Requirements
- R1: After reset all outputs are 0 and the control word holds the line loop closed with every other control clear. On the first enable after reset, `mem_bit` equals `tx_bit` and `line_bit` equals `tx_bit`, whatever the control inputs are.
- R2: With all controls clear, `line_bit` takes `tx_bit` and `mem_bit` takes `rx_bit` as sampled at the same enable.
- R3: With the line loop set and `ais_sel`=0, `mem_bit` takes the outgoing bit (`tx_bit`) in place of `rx_bit`, and `line_bit` still carries `tx_bit`.
- R4: With the line loop set and `ais_sel`=1, `line_bit` is 1 on every enable and `mem_bit` still takes `tx_bit`.
- R5: With only the codec loop set, `line_bit` takes `rx_bit`, and `mem_bit` also keeps taking `rx_bit`.
- R6: With only the frame loop set, `mem_bit` takes `tx_bit` and `line_bit` takes `tx_bit`.
- R7: With `alarm_en`=1 and `ais_sel`=1, `line_bit` is 1 on every enable, whatever the loop settings are.
- R8: With `alarm_en`=1 and `ais_sel`=0, `line_bit` follows 0,1,0,1,… and starts at 0 on the first enable in that mode.
- R9: With `pulse_test`=1, `line_bit` is 0. A one-enable pulse appears on the rails on the first enable in the mode and on every 8th enable after it. The first pulse is on `line_p` and the pulses then alternate between `line_n` and `line_p`.
- R10: For the line output, `pulse_test` overrides `alarm_en`, which overrides the line loop. When the line loop is set, it overrides both the frame loop and the codec loop.
- R11: Outputs change only on an enable. A control input change affects the outputs on the second enable after it is applied.
- R12: `line_p` and `line_n` are never 1 together, and both are 0 when `pulse_test` is not in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Bit-rate clock enable |
| rx_bit | input | 1 | Binary bit from the line decoder |
| tx_bit | input | 1 | Binary bit from the frame transmitter |
| lp_line | input | 1 | Close the loop at the line pins |
| lp_codec | input | 1 | Close the loop between decoder and encoder |
| lp_frame | input | 1 | Feed transmitter frames into frame memory |
| alarm_en | input | 1 | Replace the line output with an alarm pattern |
| ais_sel | input | 1 | 1 = all ones, 0 = alternating pattern; also masks the line loop |
| pulse_test | input | 1 | Alternating single-pulse test mode |
| line_bit | output | 1 | Binary bit to the line encoder |
| line_p | output | 1 | Positive test pulse rail |
| line_n | output | 1 | Negative test pulse rail |
| mem_bit | output | 1 | Bit to frame memory |

## Verification
Every mode is driven with differing `rx_bit` and `tx_bit` values, so each output shows which source was chosen. The alarm test runs six enables to separate the alternating pattern from a stuck level or an inverted start. The pulse test runs seventeen enables to pin down both the eight-enable spacing and the alternation of polarity. Conflicting settings are applied together: ASP with ALS, the line loop with the frame loop, and the line loop with the codec loop. These runs confirm which control wins.

// File: rtl/e1_line_loop.sv
module e1_line_loop #(
  parameter int PULSE_GAP = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_bit,
  input  logic tx_bit,
  input  logic lp_line,
  input  logic lp_codec,
  input  logic lp_frame,
  input  logic alarm_en,
  input  logic ais_sel,
  input  logic pulse_test,
  output logic line_bit,
  output logic line_p,
  output logic line_n,
  output logic mem_bit
);
  localparam int CW = (PULSE_GAP > 1) ? $clog2(PULSE_GAP) : 1;
  localparam logic [5:0] CTL_RST = 6'b100000;

  // {line loop, codec loop, frame loop, alarm, ais select, pulse test}
  logic [5:0] ctl_q;
  logic [CW-1:0] cnt_q;
  logic pol_q, alt_q;

  wire c_lp1 = ctl_q[5];
  wire c_lp2 = ctl_q[4];
  wire c_lp3 = ctl_q[3];
  wire c_als = ctl_q[2];
  wire c_ais = ctl_q[1];
  wire c_asp = ctl_q[0];

  wire tx_src   = (c_lp2 && !c_lp1) ? rx_bit : tx_bit;
  wire rx_src   = (c_lp1 || c_lp3) ? tx_bit : rx_bit;
  wire alt_mode = c_als && !c_ais && !c_asp;
  wire pulse_now = c_asp && (cnt_q == '0);

  logic line_d;
  always_comb begin
    if (c_asp)                line_d = 1'b0;
    else if (c_als)           line_d = c_ais ? 1'b1 : alt_q;
    else if (c_lp1 && c_ais)  line_d = 1'b1;
    else                      line_d = tx_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= CTL_RST;
    else if (bit_en) ctl_q <= {lp_line, lp_codec, lp_frame, alarm_en, ais_sel, pulse_test};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pol_q <= 1'b0;
    end else if (!c_asp) begin
      cnt_q <= '0;
      pol_q <= 1'b0;
    end else if (bit_en) begin
      cnt_q <= (cnt_q == CW'(PULSE_GAP - 1)) ? '0 : cnt_q + 1'b1;
      if (pulse_now) pol_q <= ~pol_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        alt_q <= 1'b0;
    else if (!alt_mode) alt_q <= 1'b0;
    else if (bit_en)   alt_q <= ~alt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_bit <= 1'b0;
      line_p   <= 1'b0;
      line_n   <= 1'b0;
      mem_bit  <= 1'b0;
    end else if (bit_en) begin
      line_bit <= line_d;
      line_p   <= pulse_now && !pol_q;
      line_n   <= pulse_now && pol_q;
      mem_bit  <= rx_src;
    end
  end
endmodule

// File: rtl/e1_line_loop_chk.sv
module e1_line_loop_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic       rx_bit,
  input logic       tx_bit,
  input logic [5:0] ctl_q,
  input logic       line_bit,
  input logic       line_p,
  input logic       line_n,
  input logic       mem_bit
);
  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable({line_bit, line_p, line_n, mem_bit}));                         // R11
  AST_RAILS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_p && line_n));                                                                // R12
  AST_RAILS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !ctl_q[0]) |=> !line_p && !line_n);                                      // R12
  AST_PULSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && ctl_q[0]) |=> !line_bit);                                                 // R9
  AST_AIS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && ctl_q[2] && ctl_q[1] && !ctl_q[0]) |=> line_bit);                         // R7
  AST_LP1_AIS: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && ctl_q[5] && ctl_q[1] && !ctl_q[0]) |=> line_bit);                         // R4
  AST_CODEC_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && ctl_q[4] && !ctl_q[5] && !ctl_q[2] && !ctl_q[0]) |=> line_bit == $past(rx_bit)); // R5
  AST_MEM_LOOPED: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && (ctl_q[5] || ctl_q[3])) |=> mem_bit == $past(tx_bit));                  // R6
  AST_MEM_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !ctl_q[5] && !ctl_q[3]) |=> mem_bit == $past(rx_bit));                  // R2
endmodule

bind e1_line_loop e1_line_loop_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit), .tx_bit(tx_bit),
  .ctl_q(ctl_q), .line_bit(line_bit), .line_p(line_p), .line_n(line_n), .mem_bit(mem_bit)
);

// File: tb/e1_line_loop_bench.sv
module e1_line_loop_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, rx_bit = 1'b0, tx_bit = 1'b0;
  logic lp_line = 1'b0, lp_codec = 1'b0, lp_frame = 1'b0;
  logic alarm_en = 1'b0, ais_sel = 1'b0, pulse_test = 1'b0;
  logic line_bit, line_p, line_n, mem_bit;
  int vectors = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  e1_line_loop u_e1_line_loop (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk) bit_en = 1'b1;
    @(negedge clk) bit_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic step(input logic r, input logic t);
    rx_bit = r; tx_bit = t;
    tick();
  endtask

  task automatic set_ctl(input logic l1, l2, l3, al, ai, ap);
    lp_line = l1; lp_codec = l2; lp_frame = l3;
    alarm_en = al; ais_sel = ai; pulse_test = ap;
    tick();
  endtask

  task automatic t_reset();
    chk("R1 line reset", line_bit, 1'b0);
    chk("R1 mem reset", mem_bit, 1'b0);
    chk("R1 rail p reset", line_p, 1'b0);
    chk("R1 rail n reset", line_n, 1'b0);
    step(1'b0, 1'b1);
    chk("R1 mem from tx via line loop", mem_bit, 1'b1);
    chk("R1 line transparent", line_bit, 1'b1);
    step(1'b1, 1'b0);
    chk("R11 ctl now clear, mem rx", mem_bit, 1'b1);
    chk("R11 ctl now clear, line tx", line_bit, 1'b0);
  endtask

  task automatic t_normal();
    set_ctl(0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 4; k++) begin
      step(k[0], k[1]);
      chk("R2 line", line_bit, k[1]);
      chk("R2 mem", mem_bit, k[0]);
    end
    rx_bit = ~rx_bit; tx_bit = ~tx_bit;
    repeat (4) @(negedge clk);
    chk("R11 hold line", line_bit, 1'b1);
    chk("R11 hold mem", mem_bit, 1'b1);
  endtask

  task automatic t_ctl_latency();
    set_ctl(0, 0, 0, 0, 0, 0);
    step(1'b0, 1'b1);
    lp_codec = 1'b1;
    step(1'b0, 1'b1);
    chk("R11 first enable old ctl", line_bit, 1'b1);
    step(1'b0, 1'b1);
    chk("R11 second enable new ctl", line_bit, 1'b0);
  endtask

  task automatic t_lp1();
    set_ctl(1, 0, 0, 0, 0, 0);
    step(1'b0, 1'b1);
    chk("R3 mem", mem_bit, 1'b1);
    chk("R3 line", line_bit, 1'b1);
    step(1'b1, 1'b0);
    chk("R3 mem", mem_bit, 1'b0);
    chk("R3 line", line_bit, 1'b0);
    set_ctl(1, 0, 0, 0, 1, 0);
    step(1'b1, 1'b0);
    chk("R4 line ones", line_bit, 1'b1);
    chk("R4 mem", mem_bit, 1'b0);
    step(1'b0, 1'b1);
    chk("R4 line ones", line_bit, 1'b1);
    chk("R4 mem", mem_bit, 1'b1);
  endtask

  task automatic t_lp2();
    set_ctl(0, 1, 0, 0, 0, 0);
    step(1'b1, 1'b0);
    chk("R5 line", line_bit, 1'b1);
    chk("R5 mem", mem_bit, 1'b1);
    step(1'b0, 1'b1);
    chk("R5 line", line_bit, 1'b0);
    chk("R5 mem", mem_bit, 1'b0);
  endtask

  task automatic t_lp3();
    set_ctl(0, 0, 1, 0, 0, 0);
    step(1'b0, 1'b1);
    chk("R6 mem", mem_bit, 1'b1);
    chk("R6 line", line_bit, 1'b1);
    step(1'b1, 1'b0);
    chk("R6 mem", mem_bit, 1'b0);
    chk("R6 line", line_bit, 1'b0);
  endtask

  task automatic t_alarms();
    set_ctl(0, 1, 0, 1, 1, 0);
    step(1'b0, 1'b0);
    chk("R7 ones over codec loop", line_bit, 1'b1);
    step(1'b0, 1'b0);
    chk("R7 ones", line_bit, 1'b1);
    set_ctl(0, 0, 0, 1, 0, 0);
    for (int k = 0; k < 6; k++) begin
      step(1'b1, 1'b1);
      chk("R8 alternating", line_bit, logic'(k % 2));
    end
  endtask

  task automatic t_pulse();
    set_ctl(0, 0, 0, 1, 1, 1);
    for (int k = 0; k < 17; k++) begin
      step(1'b1, 1'b1);
      chk("R9 line quiet", line_bit, 1'b0);
      chk("R9 rail p", line_p, logic'((k % 8 == 0) && ((k / 8) % 2 == 0)));
      chk("R9 rail n", line_n, logic'((k % 8 == 0) && ((k / 8) % 2 == 1)));
    end
    set_ctl(0, 0, 0, 0, 0, 0);
    step(1'b0, 1'b0);
    chk("R12 rails idle p", line_p, 1'b0);
    chk("R12 rails idle n", line_n, 1'b0);
  endtask

  task automatic t_priority();
    set_ctl(1, 0, 1, 0, 1, 0);
    step(1'b1, 1'b0);
    chk("R10 line loop over frame loop, line", line_bit, 1'b1);
    chk("R10 line loop over frame loop, mem", mem_bit, 1'b0);
    set_ctl(1, 1, 0, 0, 0, 0);
    step(1'b1, 1'b0);
    chk("R10 line loop over codec loop, line", line_bit, 1'b0);
    chk("R10 line loop over codec loop, mem", mem_bit, 1'b0);
    set_ctl(1, 0, 0, 1, 0, 0);
    step(1'b0, 1'b1);
    chk("R10 alarm over line loop", line_bit, 1'b0);
    step(1'b0, 1'b1);
    chk("R10 alarm over line loop", line_bit, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_ctl_latency();
    t_lp1();
    t_lp2();
    t_lp3();
    t_alarms();
    t_pulse();
    t_priority();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #1ms;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule